// File: doc/BRIEF.md
# Dual-Mode Parallel Integer Multiplier

This block multiplies two N-bit operands in a single combinational pass and returns the full 2N-bit product. One mode input chooses how the operands are read: as plain binary magnitudes, or as two's-complement values. Both readings share one datapath. The mode bit only changes how partial products and intermediate sums are widened. It also decides whether the top partial product is replaced by the negated multiplicand.

Every partial product is formed at the same time by gating the multiplicand with one multiplier bit. Neighbouring even/odd partial products are added first in ripple adders that are N+2 bits wide. The pair sums are then merged through a balanced binary tree until one sum remains. When the multiplier is negative in signed mode, the last partial product is negated. This uses an XOR-gated inversion of the multiplicand, a pad bit of one and a carry-in of one into its pair adder.

The block has no clock and no state. The datapath width N must be even, with a default of 4. It is used as a drop-in arithmetic unit wherever a product must be produced within one combinational path.

Top module: `dualmode_mult`

## Requirements
- R1: With signedMode = 0, product equals opA times opB, with both operands taken as unsigned N-bit values, for every operand pair.
- R2: With signedMode = 1, product equals the two's-complement product of opA and opB, kept to 2N bits with any carry beyond bit 2N-1 discarded, for every operand pair.
- R3: With signedMode = 1, the most negative value times itself gives +2^(2N-2). The most negative value times the most positive value gives the matching negative result.
- R4: The pad bit and the carry-in for the top partial product are both 1 exactly when signedMode = 1 and opB[N-1] = 1. A signed multiplier of -1 therefore yields the negated multiplicand, sign-extended.
- R5: If either operand is zero, product is zero in both modes.
- R6: With opB = 1, product equals opA zero-extended when signedMode = 0 and sign-extended when signedMode = 1.
- R7: With signedMode = 0, the upper half product[2N-1:N] never exceeds either operand. This means no carry leaves the 2N-bit result.
- R8: With signedMode = 1 and both operands nonzero, product[2N-1] equals opA[N-1] XOR opB[N-1].
- R9: When opA[N-1] and opB[N-1] are both 0, product is the same in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | Multiplicand |
| opB | input | N | Multiplier |
| signedMode | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| product | output | 2N | Full-width product |

## Verification
The immediate assertions assume that all three inputs hold known values and have settled before they are evaluated. They also assume that N is even, so that the top partial product is always the odd member of the last pair. The stimulus changes operands only from tasks. It then waits one time unit before sampling, so each comparison sees a settled combinational result.

Every operand pair is swept in both modes, at the default width of 4 and again at a width of 8. This covers the most negative operands and the negated top partial product for all multiplicands.

// File: rtl/dualmode_mult_pkg.sv
package dualmode_mult_pkg;

  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic extSign;   // widen partial products and sums with their sign bit
    logic negLast;   // invert the multiplicand in the top partial product
    logic padBit;    // low-order pad of the top partial product
    logic carryIn;   // carry into the adder of the last pair
  } mulStrobe_t;

  // depth of heap node k (root is depth 0)
  function automatic int heapDepth(input int k);
    return $clog2(k + 2) - 1;
  endfunction

endpackage

// File: rtl/dualmode_mult_ctrl.sv
module dualmode_mult_ctrl
  import dualmode_mult_pkg::*;
(
  input  logic       signedMode,
  input  logic       bMsb,
  output mulStrobe_t strb
);

  logic negate;

  always_comb begin
    negate       = signedMode & bMsb;
    strb.extSign = signedMode;
    strb.negLast = negate;
    strb.padBit  = negate;
    strb.carryIn = negate;
  end

endmodule

// File: rtl/dualmode_mult_datapath.sv
module dualmode_mult_datapath
  import dualmode_mult_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  mulStrobe_t     strb,
  output logic [2*N-1:0] product
);

  localparam int NPAIR = N / 2;
  localparam int LV    = $clog2(NPAIR);
  localparam int NLEAF = 1 << LV;
  localparam int NNODE = 2 * NLEAF - 1;
  localparam int PW    = N + 2;            // pair adder width
  localparam int WTOP  = N + 2 * NLEAF;    // tree node width

  logic [N-1:0]    pp   [N];
  logic [WTOP-1:0] tree [NNODE];

  // partial products, the top one with gated inversion
  for (genvar i = 0; i < N; i++) begin : gPp
    if (i == N - 1) begin : gTop
      assign pp[i] = (opA & {N{opB[i]}}) ^ {N{strb.negLast}};
    end else begin : gMid
      assign pp[i] = opA & {N{opB[i]}};
    end
  end

  // leaves: even/odd pair adders
  for (genvar j = 0; j < NLEAF; j++) begin : gLeaf
    if (j < NPAIR) begin : gPair
      logic [PW-1:0] evenExt, oddExt, pairSum;
      logic          padLo, cin;
      assign padLo   = (j == NPAIR - 1) ? strb.padBit  : 1'b0;
      assign cin     = (j == NPAIR - 1) ? strb.carryIn : 1'b0;
      assign evenExt = strb.extSign ? PW'($signed(pp[2*j])) : PW'(pp[2*j]);
      assign oddExt  = {strb.extSign & pp[2*j+1][N-1], pp[2*j+1], padLo};
      assign pairSum = evenExt + oddExt + PW'(cin);
      assign tree[NLEAF - 1 + j] = strb.extSign ? WTOP'($signed(pairSum))
                                                : WTOP'(pairSum);
    end else begin : gEmpty
      assign tree[NLEAF - 1 + j] = '0;
    end
  end

  // internal nodes: lower child widened, upper child shifted
  for (genvar k = 0; k < NLEAF - 1; k++) begin : gNode
    localparam int SH = 1 << (LV - heapDepth(k));
    assign tree[k] = tree[2*k+1] + (tree[2*k+2] << SH);
  end

  assign product = tree[0][2*N-1:0];

  always_comb begin
    // R5
    if (opA == '0 || opB == '0) begin
      zero_operand_chk: assert (product == '0);
    end
    // R7
    if (!strb.extSign) begin
      unsigned_hi_chk: assert (product[2*N-1:N] <= opA && product[2*N-1:N] <= opB);
    end
    // R8
    if (strb.extSign && opA != '0 && opB != '0) begin
      sign_rule_chk: assert (product[2*N-1] == (opA[N-1] ^ opB[N-1]));
    end
    // R6
    if (opB == N'(1)) begin
      unit_mult_chk: assert (product[N-1:0] == opA);
    end
  end

endmodule

// File: rtl/dualmode_mult.sv
module dualmode_mult
  import dualmode_mult_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  logic           signedMode,
  output logic [2*N-1:0] product
);

  mulStrobe_t strb;

  dualmode_mult_ctrl uCtrl (
    .signedMode (signedMode),
    .bMsb       (opB[N-1]),
    .strb       (strb)
  );

  dualmode_mult_datapath #(.N(N)) uPath (
    .opA     (opA),
    .opB     (opB),
    .strb    (strb),
    .product (product)
  );

  always_comb begin
    // R4
    pad_carry_chk: assert (strb.padBit == (signedMode & opB[N-1]) &&
                           strb.carryIn == (signedMode & opB[N-1]));
  end

endmodule

// File: tb/tb_dualmode_mult.sv
`timescale 1ns/1ps
module tb_dualmode_mult;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [3:0] a4 = '0, b4 = '0;
  logic       m4 = 1'b0;
  logic [7:0] p4;
  logic [7:0] a8 = '0, b8 = '0;
  logic       m8 = 1'b0;
  logic [15:0] p8;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dualmode_mult #(.N(4)) dut (.opA(a4), .opB(b4), .signedMode(m4), .product(p4));
  dualmode_mult #(.N(8)) dut8 (.opA(a8), .opB(b8), .signedMode(m8), .product(p8));

  function automatic longint refMul(int a, int b, bit s, int n);
    longint sa = a, sb = b;
    if (s && a >= (1 << (n - 1))) sa = a - (1 << n);
    if (s && b >= (1 << (n - 1))) sb = b - (1 << n);
    return (sa * sb) & ((64'sd1 <<< (2 * n)) - 1);
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic drive4(int a, int b, bit s);
    a4 = 4'(a); b4 = 4'(b); m4 = s; #1;
  endtask

  task automatic drive8(int a, int b, bit s);
    a8 = 8'(a); b8 = 8'(b); m8 = s; #1;
  endtask

  // initial zero inputs give zero output (R5)
  task automatic tIdle();
    #1;
    chk("R5 idle n4", 16'(p4), 16'h0);
    chk("R5 idle n8", p8, 16'h0);
  endtask

  // full sweep unsigned (R1, R7)
  task automatic tUnsignedSweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drive4(a, b, 1'b0);
        chk("R1 n4", 16'(p4), 16'(refMul(a, b, 1'b0, 4)));
        chk("R7 n4", 16'(p4[7:4] <= a4 && p4[7:4] <= b4), 16'd1);
      end
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        drive8(a, b, 1'b0);
        chk("R1 n8", p8, 16'(refMul(a, b, 1'b0, 8)));
      end
  endtask

  // full sweep signed (R2, R8)
  task automatic tSignedSweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drive4(a, b, 1'b1);
        chk("R2 n4", 16'(p4), 16'(refMul(a, b, 1'b1, 4)));
        if (a != 0 && b != 0)
          chk("R8 n4", 16'(p4[7]), 16'(a4[3] ^ b4[3]));
      end
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        drive8(a, b, 1'b1);
        chk("R2 n8", p8, 16'(refMul(a, b, 1'b1, 8)));
      end
  endtask

  // most negative and most positive operands (R3)
  task automatic tExtremes();
    drive4(8, 8, 1'b1);    chk("R3 min*min n4", 16'(p4), 16'h0040);
    drive4(8, 7, 1'b1);    chk("R3 min*max n4", 16'(p4), 16'h00C8);
    drive8(128, 128, 1'b1); chk("R3 min*min n8", p8, 16'h4000);
    drive8(128, 127, 1'b1); chk("R3 min*max n8", p8, 16'hC080);
  endtask

  // negative multiplier drives negation of top partial product (R4)
  task automatic tNegMultiplier();
    drive4(5, 15, 1'b1);   chk("R4 5*-1 n4", 16'(p4), 16'h00FB);
    drive4(8, 15, 1'b1);   chk("R4 -8*-1 n4", 16'(p4), 16'h0008);
    drive4(5, 15, 1'b0);   chk("R4 unsigned 5*15 n4", 16'(p4), 16'h004B);
    drive8(3, 255, 1'b1);  chk("R4 3*-1 n8", p8, 16'hFFFD);
  endtask

  // zero operands (R5)
  task automatic tZeroOps();
    drive4(0, 9, 1'b1);    chk("R5 0*b n4", 16'(p4), 16'h0);
    drive4(13, 0, 1'b0);   chk("R5 a*0 n4", 16'(p4), 16'h0);
    drive8(200, 0, 1'b1);  chk("R5 a*0 n8", p8, 16'h0);
  endtask

  // unit multiplier (R6)
  task automatic tUnit();
    drive4(11, 1, 1'b0);   chk("R6 zext n4", 16'(p4), 16'h000B);
    drive4(11, 1, 1'b1);   chk("R6 sext n4", 16'(p4), 16'h00FB);
    drive8(129, 1, 1'b1);  chk("R6 sext n8", p8, 16'hFF81);
  endtask

  // same product when both MSBs are clear (R9)
  task automatic tModeMatch();
    logic [7:0] pu;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        drive4(a, b, 1'b0); pu = p4;
        drive4(a, b, 1'b1);
        chk("R9 n4", 16'(p4), 16'(pu));
      end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    tIdle();
    tZeroOps();
    tUnit();
    tExtremes();
    tNegMultiplier();
    tModeMatch();
    tUnsignedSweep();
    tSignedSweep();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule